// File: doc/BRIEF.md
# Streaming Matrix-Vector Threshold Unit

This block multiplies a stream of input activation vectors by a stored weight matrix and turns each dot product directly into a low-precision output activation. It does not emit the sum. Each output is the number of stored per-channel thresholds that the sum reaches, so normalization and quantization become a single comparison stage. P processing elements work side by side, each on a different output channel. Every clock each element multiplies Q input elements by Q signed weights, reduces the Q products in an adder tree, and adds the tree result into a signed accumulator. A vector of length D therefore takes D/Q folds for each group of P output channels, and the OC output channels form OC/P groups.

Input chunks arrive on a valid/ready stream, Q elements per beat, and D/Q beats make one vector. The block reads them from the stream while it computes output group 0 and keeps a copy, so the later groups reuse the vector without asking for it again. `in_ready` is low while those later groups are computed. It is also low while a finished result is waiting on a stalled output. An output beat carries the P activations of one group and stays valid and unchanged until `out_ready` accepts it. No result is ever dropped. The weight and threshold memories are written through a simple load port. Software loads them while no vector is in flight.

Top module: `mvt_unit`

## Requirements
- R1: For output channel c = g*P + p, the field `out_data[p*A +: A]` of output beat g equals the number of that channel's 2^A-1 thresholds t with t <= S. S is the signed sum of x[d]*w[c][d] over d = 0..D-1, where x is unsigned IA-bit and w is a two's-complement W-bit weight. Input element f*Q+k travels in `in_data[k*IA +: IA]` of beat f.
- R2: The accumulator starts from zero at the first fold of every output group. No partial sum from an earlier group or vector changes a later result.
- R3: Each input vector produces exactly OC/P output beats, in group order 0, 1, ... OC/P-1. The next vector starts again at group 0 with weight row 0.
- R4: Exactly D/Q input beats are accepted per vector. `in_ready` is low while groups 1 and later are being computed.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid` stays high, `out_data` holds its value and `in_ready` is low.
- R6: After reset `out_valid` is 0 and `in_ready` is 1.
- R7: A load with `ld_kind`=0 writes `ld_data[k*W +: W]` as the weight for element f*Q+k of channel g*P+`ld_pe`, at `ld_addr` = g*(D/Q)+f. A load with `ld_kind`=1 writes the signed value `ld_data` as threshold i of that channel, at `ld_addr` = g*(2^A-1)+i. The thresholds of each channel are stored in ascending order.
- R8: A sum exactly equal to a threshold counts that threshold (greater-or-equal comparison).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Memory load strobe |
| ld_kind | input | 1 | 0 = weight word, 1 = threshold |
| ld_pe | input | max(1,clog2(P)) | Target processing element |
| ld_addr | input | LAW | Row address inside the target memory |
| ld_data | input | LDW | Packed weights or one signed threshold |
| in_valid | input | 1 | Input chunk valid |
| in_ready | output | 1 | Input chunk accepted when high with in_valid |
| in_data | input | Q*IA | Q unsigned activations |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts output beat |
| out_data | output | P*A | P output activations of one group |

## Verification
The hardest situation to reach is a stall that comes while the block still owes later output groups for a vector. The finished result must be held, the unit must neither advance nor take new input, and the remaining groups must come out in order after the release. The bench holds `out_ready` low through a whole vector, watches the held beat and `in_ready` for several cycles, then releases it and checks every group. A second hard case is a sum that lands exactly on a threshold. The bench computes the sums of a vector itself and reloads every channel's thresholds as sum-1, sum and sum+1, which makes the count depend on the equality case alone.

// File: rtl/mvt_pkg.sv
package mvt_pkg;
  typedef enum logic {LD_WEIGHT = 1'b0, LD_THRESH = 1'b1} ld_kind_e;

  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/mvt_ctrl.sv
module mvt_ctrl #(
  parameter int F  = 2,
  parameter int G  = 2,
  parameter int FW = 1,
  parameter int GW = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [FW-1:0] fold,
  output logic [GW-1:0] grp,
  output logic          first,
  output logic          last
);
  assign first = (fold == '0);
  assign last  = (fold == FW'(F - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fold <= '0;
      grp  <= '0;
    end else if (adv) begin
      if (last) begin
        fold <= '0;
        grp  <= (grp == GW'(G - 1)) ? '0 : grp + GW'(1);
      end else begin
        fold <= fold + FW'(1);
      end
    end
  end
endmodule

// File: rtl/mvt_vecbuf.sv
module mvt_vecbuf #(
  parameter int F  = 2,
  parameter int CW = 8,
  parameter int FW = 1
) (
  input  logic          clk,
  input  logic          capture,
  input  logic          live,
  input  logic [FW-1:0] fold,
  input  logic [CW-1:0] in_chunk,
  output logic [CW-1:0] chunk
);
  logic [CW-1:0] vec_q [F];

  always_ff @(posedge clk) begin
    if (capture) vec_q[fold] <= in_chunk;
  end

  assign chunk = live ? in_chunk : vec_q[fold];
endmodule

// File: rtl/mvt_pe.sv
module mvt_pe #(
  parameter int Q    = 2,
  parameter int W    = 2,
  parameter int IA   = 4,
  parameter int A    = 2,
  parameter int F    = 2,
  parameter int G    = 2,
  parameter int ACCW = 10,
  parameter int FW   = 1,
  parameter int GW   = 1,
  parameter int LAW  = 3,
  parameter int LDW  = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we_w,
  input  logic            we_t,
  input  logic [LAW-1:0]  ld_addr,
  input  logic [LDW-1:0]  ld_data,
  input  logic [Q*IA-1:0] chunk,
  input  logic [FW-1:0]   fold,
  input  logic [GW-1:0]   grp,
  input  logic            fire,
  input  logic            first,
  output logic [A-1:0]    act
);
  localparam int NT  = (1 << A) - 1;
  localparam int PW  = IA + W + 1;
  localparam int WAW = mvt_pkg::idx_w(G * F);
  localparam int TAW = mvt_pkg::idx_w(G * NT);

  logic [Q*W-1:0]         wmem [G*F];
  logic signed [ACCW-1:0] tmem [G*NT];
  logic signed [ACCW-1:0] acc_q, tree, total;
  logic signed [PW-1:0]   prod [Q];
  logic [Q*W-1:0]         wrow;
  logic [WAW-1:0]         waddr;
  logic [TAW-1:0]         tbase;

  always_ff @(posedge clk) begin
    if (we_w) wmem[ld_addr[WAW-1:0]] <= ld_data[Q*W-1:0];
    if (we_t) tmem[ld_addr[TAW-1:0]] <= ld_data[ACCW-1:0];
  end

  assign waddr = WAW'(grp) * WAW'(F) + WAW'(fold);
  assign tbase = TAW'(grp) * TAW'(NT);
  assign wrow  = wmem[waddr];

  for (genvar k = 0; k < Q; k++) begin : g_lane
    assign prod[k] = $signed({1'b0, chunk[k*IA +: IA]}) * $signed(wrow[k*W +: W]);
  end

  always_comb begin
    tree = '0;
    for (int k = 0; k < Q; k++)
      tree = tree + {{(ACCW-PW){prod[k][PW-1]}}, prod[k]};
  end

  assign total = (first ? '0 : acc_q) + tree;

  always_ff @(posedge clk) begin
    if (!rst_n)    acc_q <= '0;
    else if (fire) acc_q <= total;
  end

  always_comb begin
    act = '0;
    for (int i = 0; i < NT; i++)
      if (tmem[tbase + TAW'(i)] <= total) act = act + A'(1);
  end
endmodule

// File: rtl/mvt_unit.sv
module mvt_unit
  import mvt_pkg::*;
#(
  parameter int P  = 2,
  parameter int Q  = 2,
  parameter int D  = 4,
  parameter int OC = 4,
  parameter int W  = 2,
  parameter int IA = 4,
  parameter int A  = 2,
  localparam int F    = D / Q,
  localparam int G    = OC / P,
  localparam int NT   = (1 << A) - 1,
  localparam int ACCW = IA + W + 2 + $clog2(D),
  localparam int PSW  = idx_w(P),
  localparam int FW   = idx_w(F),
  localparam int GW   = idx_w(G),
  localparam int LAW  = (idx_w(G * F) > idx_w(G * NT)) ? idx_w(G * F) : idx_w(G * NT),
  localparam int LDW  = (Q * W > ACCW) ? Q * W : ACCW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_valid,
  input  logic            ld_kind,
  input  logic [PSW-1:0]  ld_pe,
  input  logic [LAW-1:0]  ld_addr,
  input  logic [LDW-1:0]  ld_data,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [Q*IA-1:0] in_data,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [P*A-1:0]  out_data
);
  ld_kind_e        kind;
  logic [FW-1:0]   fold;
  logic [GW-1:0]   grp;
  logic            first, last, live, slot_free, fire;
  logic [Q*IA-1:0] chunk;
  logic [P*A-1:0]  acts;

  assign kind      = ld_kind_e'(ld_kind);
  assign live      = (grp == '0);
  assign slot_free = !out_valid || out_ready;
  assign in_ready  = live && slot_free;
  assign fire      = slot_free && (live ? in_valid : 1'b1);

  mvt_ctrl #(.F(F), .G(G), .FW(FW), .GW(GW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .adv(fire),
    .fold(fold), .grp(grp), .first(first), .last(last)
  );

  mvt_vecbuf #(.F(F), .CW(Q*IA), .FW(FW)) u_vbuf (
    .clk(clk), .capture(fire && live), .live(live), .fold(fold),
    .in_chunk(in_data), .chunk(chunk)
  );

  for (genvar p = 0; p < P; p++) begin : g_pe
    mvt_pe #(
      .Q(Q), .W(W), .IA(IA), .A(A), .F(F), .G(G), .ACCW(ACCW),
      .FW(FW), .GW(GW), .LAW(LAW), .LDW(LDW)
    ) u_pe (
      .clk(clk), .rst_n(rst_n),
      .we_w(ld_valid && kind == LD_WEIGHT && ld_pe == PSW'(p)),
      .we_t(ld_valid && kind == LD_THRESH && ld_pe == PSW'(p)),
      .ld_addr(ld_addr), .ld_data(ld_data),
      .chunk(chunk), .fold(fold), .grp(grp),
      .fire(fire), .first(first),
      .act(acts[p*A +: A])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (fire && last) begin
      out_valid <= 1'b1;
      out_data  <= acts;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/mvt_unit_chk.sv
module mvt_unit_chk #(
  parameter int P  = 2,
  parameter int Q  = 2,
  parameter int D  = 4,
  parameter int OC = 4,
  parameter int A  = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_ready,
  input logic           out_valid,
  input logic           out_ready,
  input logic [P*A-1:0] out_data
);
  localparam int F = D / Q;
  localparam int G = OC / P;

  int  in_cnt, out_cnt;
  logic in_hs, out_hs, out_end;

  assign in_hs   = in_valid && in_ready;
  assign out_hs  = out_valid && out_ready;
  assign out_end = out_hs && (out_cnt == G - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_cnt  <= 0;
      out_cnt <= 0;
    end else begin
      in_cnt  <= (out_end ? 0 : in_cnt) + (in_hs ? 1 : 0);
      if (out_hs) out_cnt <= out_end ? 0 : out_cnt + 1;
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R5
  AST_NO_IN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R5
  AST_IN_BEATS: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready && !out_hs |-> in_cnt < F); // R4
  AST_OUT_AFTER_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_cnt == F); // R4
endmodule

bind mvt_unit mvt_unit_chk #(.P(P), .Q(Q), .D(D), .OC(OC), .A(A)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/mvt_unit_test.sv
module mvt_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int P = 2, Q = 2, D = 4, OC = 4, W = 2, IA = 4, A = 2;
  localparam int F = D / Q, G = OC / P, NT = (1 << A) - 1;
  localparam int LAW = 3, LDW = 10;

  logic clk = 0, rst_n = 0;
  logic ld_valid = 0, ld_kind = 0;
  logic [0:0] ld_pe = '0;
  logic [LAW-1:0] ld_addr = '0;
  logic [LDW-1:0] ld_data = '0;
  logic in_valid = 0, in_ready;
  logic [Q*IA-1:0] in_data = '0;
  logic out_valid, out_ready = 1;
  logic [P*A-1:0] out_data;

  int errors = 0, checks = 0;
  int wt [OC][D];
  int thr [OC][NT];
  int cur_x [D];
  logic [P*A-1:0] got [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  mvt_unit uut (.*);

  always @(negedge clk) if (out_valid && out_ready) got.push_back(out_data);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic ld(input bit kind, input int pe, input int addr, input int data);
    ld_valid = 1; ld_kind = kind; ld_pe = pe[0:0];
    ld_addr = addr[LAW-1:0]; ld_data = data[LDW-1:0];
    step();
    ld_valid = 0;
  endtask

  task automatic load_all();
    for (int c = 0; c < OC; c++) begin
      for (int f = 0; f < F; f++) begin
        int word = 0;
        for (int k = 0; k < Q; k++) word |= (wt[c][f*Q+k] & 3) << (k*W);
        ld(1'b0, c % P, (c / P) * F + f, word);
      end
      for (int i = 0; i < NT; i++) ld(1'b1, c % P, (c / P) * NT + i, thr[c][i]);
    end
  endtask

  function automatic int dot(input int c);
    int s = 0;
    for (int d = 0; d < D; d++) s += cur_x[d] * wt[c][d];
    return s;
  endfunction

  function automatic int expect_act(input int c);
    int n = 0;
    for (int i = 0; i < NT; i++) if (thr[c][i] <= dot(c)) n++;
    return n;
  endfunction

  task automatic send_vector();
    for (int f = 0; f < F; f++) begin
      in_valid = 1;
      for (int k = 0; k < Q; k++) in_data[k*IA +: IA] = cur_x[f*Q+k][IA-1:0];
      forever begin
        @(negedge clk);
        if (in_ready) begin step(); break; end
        step();
      end
    end
    in_valid = 0;
  endtask

  task automatic collect_and_compare(input string tag);
    int waited = 0;
    while (got.size() < G && waited < 200) begin step(); waited++; end
    repeat (4) step();
    check({tag, " R3 beat count"}, got.size(), G);
    for (int g = 0; g < G && g < got.size(); g++)
      for (int p = 0; p < P; p++)
        check({tag, " R1 R2 channel value"}, int'(got[g][p*A +: A]), expect_act(g*P + p));
    got.delete();
  endtask

  task automatic run_vector(input string tag);
    send_vector();
    @(negedge clk);
    check({tag, " R4 in_ready low in later group"}, int'(in_ready), 0);
    collect_and_compare(tag);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R6 out_valid after reset", int'(out_valid), 0);
    check("R6 in_ready after reset", int'(in_ready), 1);
  endtask

  task automatic t_patterns();
    for (int d = 0; d < D; d++) cur_x[d] = 0;
    run_vector("zeros");
    for (int d = 0; d < D; d++) cur_x[d] = 15;
    run_vector("max");
    for (int d = 0; d < D; d++) cur_x[d] = (d * 7 + 3) % 16;
    run_vector("mixed");
    for (int d = 0; d < D; d++) cur_x[d] = (d % 2) ? 1 : 12;
    run_vector("alternating");
  endtask

  task automatic t_stall();
    logic [P*A-1:0] held;
    out_ready = 0;
    for (int d = 0; d < D; d++) cur_x[d] = 9 - d;
    send_vector();
    @(negedge clk);
    check("R5 out_valid during stall", int'(out_valid), 1);
    held = out_data;
    repeat (5) begin
      step(); @(negedge clk);
      check("R5 out_data held", int'(out_data), int'(held));
      check("R5 in_ready low during stall", int'(in_ready), 0);
    end
    check("R5 valid held", int'(out_valid), 1);
    step();
    out_ready = 1;
    collect_and_compare("stall");
  endtask

  task automatic t_equal();
    for (int d = 0; d < D; d++) cur_x[d] = d + 5;
    for (int c = 0; c < OC; c++) begin
      int s = dot(c);
      thr[c][0] = s - 1; thr[c][1] = s; thr[c][2] = s + 1;
    end
    load_all();
    send_vector();
    repeat (F * G + 4) step();
    check("R7 R8 beat count", got.size(), G);
    for (int g = 0; g < G && g < got.size(); g++)
      for (int p = 0; p < P; p++)
        check("R8 equal threshold counted", int'(got[g][p*A +: A]), 2);
    got.delete();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R3 watchdog expired, actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    for (int c = 0; c < OC; c++) begin
      for (int d = 0; d < D; d++) wt[c][d] = ((c * 3 + d * 5) % 4) - 2;
      thr[c][0] = -10 + c; thr[c][1] = 0; thr[c][2] = 8 + 2 * c;
    end
    repeat (3) step();
    rst_n = 1;
    t_reset();
    load_all();
    t_patterns();
    t_stall();
    t_equal();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule